// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block fronts a small word-addressed shared memory that several requesters use at once. Each requester presents an operation code, a word address and a write value, and holds them until a round-robin arbiter grants it. The granted operation reads and rewrites its word in a single clock edge, so no other store can land between the read and the write.

The unit offers plain load and store, atomic exchange, test-and-set and fetch-and-increment. It also offers a load-linked / store-conditional pair, backed by one address reservation per requester. Every operation returns either the prior memory word or a success flag. The reply appears on a shared data bus one cycle after the grant, together with a one-hot response-valid pulse to the requester that was served. Software builds spin locks, shared counters and lock-free updates on top of these primitives.

Top module: `atomic_mem_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` is all zero. After reset every memory word reads 0 and no reservation is held.
- R2: At most one grant is given per cycle, and only to a requester with `req_valid` high. The search starts at the requester after the one granted last and wraps round. After reset requester 0 ranks first.
- R3: When a grant is given in cycle t, `rsp_valid` in cycle t+1 is exactly that grant, and `rsp_data` carries its result. With no grant in cycle t, `rsp_valid` is zero in cycle t+1.
- R4: Op code 0 (load) returns the word and changes nothing. Op code 7 behaves exactly like a load.
- R5: Op code 1 (store) writes the write value and returns the prior word.
- R6: Op code 2 (exchange) writes the write value and returns the prior word in the same indivisible step.
- R7: Op code 3 (test-and-set) writes 1 and returns the prior word, so a result of 0 means the lock was free and 1 means it was taken.
- R8: Op code 4 (fetch-and-increment) returns the prior word and stores that word plus one, wrapping modulo 2^DW.
- R9: Op code 5 (load-linked) returns the word and sets the requester's reservation to that address, replacing any earlier one.
- R10: Op code 6 (store-conditional) writes and returns 1 only when the requester holds a reservation on that same address. Otherwise it returns 0 and leaves memory unchanged. In both cases the requester's reservation is cleared.
- R11: A write made by op codes 1 to 4, or by a successful store-conditional, clears the reservation of every other requester that holds that address. The writer's own reservation is not affected by op codes 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_op | input | 3*NREQ | Operation code, 3 bits per requester |
| req_addr | input | AW*NREQ | Word address, AW bits per requester |
| req_wdata | input | DW*NREQ | Write value, DW bits per requester |
| grant | output | NREQ | One-hot grant for this cycle (combinational) |
| rsp_valid | output | NREQ | One-hot response pulse, one cycle after the grant |
| rsp_data | output | DW | Prior word or success flag of the served operation |

## Verification
The hardest case to reach is a reservation that is lost to a write from a different requester. That write must fall between a load-linked and the matching store-conditional, on the same address, and the two linked operations must not be split by the arbiter in some other way. Directed sequences build this case and its neighbours: a plain store, an exchange, an increment and a successful store-conditional from another requester. Random traffic confined to four addresses and all eight op codes then makes such interleavings common, and a bench model tracks memory and reservations to predict each reply.

// File: rtl/amu_pkg.sv
package amu_pkg;
    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_SWAP   = 3'd2,
        OP_TSET   = 3'd3,
        OP_FINC   = 3'd4,
        OP_LINK   = 3'd5,
        OP_CSTORE = 3'd6,
        OP_RSVD   = 3'd7
    } amu_op_e;
endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);
    logic [IW-1:0] ptr_d, ptr_q;

    always_comb begin
        int idx;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            idx = (int'(ptr_q) + off) % N;
            if (!gnt_any && req[idx]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(idx);
            end
        end
        if (gnt_any) gnt[gnt_idx] = 1'b1;
        ptr_d = gnt_any ? gnt_idx : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= IW'(N - 1);
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/amu_alu.sv
module amu_alu
    import amu_pkg::*;
#(
    parameter int DW = 16
) (
    input  amu_op_e         op,
    input  logic [DW-1:0]   old_val,
    input  logic [DW-1:0]   wdata,
    input  logic            link_ok,
    output logic [DW-1:0]   new_val,
    output logic            wr_en,
    output logic [DW-1:0]   rsp_val
);
    always_comb begin
        new_val = old_val;
        wr_en   = 1'b0;
        rsp_val = old_val;
        case (op)
            OP_STORE, OP_SWAP: begin
                new_val = wdata;
                wr_en   = 1'b1;
            end
            OP_TSET: begin
                new_val = DW'(1);
                wr_en   = 1'b1;
            end
            OP_FINC: begin
                new_val = old_val + DW'(1);
                wr_en   = 1'b1;
            end
            OP_CSTORE: begin
                new_val = wdata;
                wr_en   = link_ok;
                rsp_val = {{(DW-1){1'b0}}, link_ok};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
    import amu_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREQ-1:0]     req_valid,
    input  logic [NREQ*3-1:0]   req_op,
    input  logic [NREQ*AW-1:0]  req_addr,
    input  logic [NREQ*DW-1:0]  req_wdata,
    output logic [NREQ-1:0]     grant,
    output logic [NREQ-1:0]     rsp_valid,
    output logic [DW-1:0]       rsp_data
);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [NREQ-1:0]          rsv_v;
        logic [NREQ-1:0][AW-1:0]  rsv_a;
        logic [NREQ-1:0]          rv;
        logic [DW-1:0]            rd;
    } state_t;

    state_t state_d, state_q;

    logic [IW-1:0] gidx;
    logic          gany;
    amu_op_e       sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic [DW-1:0] old_val;
    logic          link_ok;
    logic [DW-1:0] new_val;
    logic          wr_en;
    logic [DW-1:0] rsp_val;

    amu_rr_arb #(.N(NREQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (grant),
        .gnt_idx (gidx),
        .gnt_any (gany)
    );

    assign sel_op    = amu_op_e'(req_op[gidx*3 +: 3]);
    assign sel_addr  = req_addr[gidx*AW +: AW];
    assign sel_wdata = req_wdata[gidx*DW +: DW];
    assign old_val   = state_q.mem[sel_addr];
    assign link_ok   = state_q.rsv_v[gidx] && (state_q.rsv_a[gidx] == sel_addr);

    amu_alu #(.DW(DW)) u_alu (
        .op      (sel_op),
        .old_val (old_val),
        .wdata   (sel_wdata),
        .link_ok (link_ok),
        .new_val (new_val),
        .wr_en   (wr_en),
        .rsp_val (rsp_val)
    );

    always_comb begin
        state_d    = state_q;
        state_d.rv = '0;
        if (gany) begin
            if (wr_en) begin
                state_d.mem[sel_addr] = new_val;
                for (int i = 0; i < NREQ; i++) begin
                    if (!grant[i] && state_q.rsv_a[i] == sel_addr)
                        state_d.rsv_v[i] = 1'b0;
                end
            end
            if (sel_op == OP_LINK) begin
                state_d.rsv_v[gidx] = 1'b1;
                state_d.rsv_a[gidx] = sel_addr;
            end
            if (sel_op == OP_CSTORE)
                state_d.rsv_v[gidx] = 1'b0;
            state_d.rv = grant;
            state_d.rd = rsp_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.rv;
    assign rsp_data  = state_q.rd;
endmodule

// File: rtl/amu_check.sv
module amu_check #(
    parameter int NREQ = 4,
    parameter int DW   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req_valid,
    input logic [NREQ*3-1:0] req_op,
    input logic [NREQ-1:0]   grant,
    input logic [NREQ-1:0]   rsp_valid,
    input logic [DW-1:0]     rsp_data
);
    logic [NREQ-1:0] is_cstore;

    for (genvar g = 0; g < NREQ; g++) begin : g_dec
        assign is_cstore[g] = (req_op[g*3 +: 3] == 3'd6);
    end

    // R2: a single grant, and only to a live request
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);

    // R3: response pulse mirrors the previous cycle's grant
    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rsp_valid == $past(grant));

    // R10: store-conditional replies with a flag only
    assert_cstore_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & is_cstore)) |=> rsp_data <= DW'(1));
endmodule

bind atomic_mem_unit amu_check #(.NREQ(NREQ), .DW(DW)) u_amu_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .grant     (grant),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/test_atomic_mem_unit.sv
module test_atomic_mem_unit;
    localparam int NREQ = 4;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int DEPTH = 1 << AW;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NREQ-1:0]     req_valid;
    logic [NREQ*3-1:0]   req_op;
    logic [NREQ*AW-1:0]  req_addr;
    logic [NREQ*DW-1:0]  req_wdata;
    logic [NREQ-1:0]     grant;
    logic [NREQ-1:0]     rsp_valid;
    logic [DW-1:0]       rsp_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] m_mem [DEPTH];
    bit            m_rv  [NREQ];
    int            m_ra  [NREQ];

    atomic_mem_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) i_atomic_mem_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            default: return "R4";
        endcase
    endfunction

    // Reference model: op codes 0 load,1 store,2 swap,3 tset,4 finc,5 link,6 cstore,7 load
    task automatic model(input int r, input int op, input int a, input logic [DW-1:0] w,
                         output logic [DW-1:0] e);
        logic [DW-1:0] old, nv;
        bit wr;
        old = m_mem[a]; nv = old; wr = 0; e = old;
        case (op)
            1, 2: begin wr = 1; nv = w; end
            3: begin wr = 1; nv = DW'(1); end
            4: begin wr = 1; nv = old + DW'(1); end
            5: begin m_rv[r] = 1; m_ra[r] = a; end
            6: begin
                if (m_rv[r] && m_ra[r] == a) begin wr = 1; nv = w; e = DW'(1); end
                else e = '0;
                m_rv[r] = 0;
            end
            default: ;
        endcase
        if (wr) begin
            m_mem[a] = nv;
            for (int i = 0; i < NREQ; i++)
                if (i != r && m_rv[i] && m_ra[i] == a) m_rv[i] = 0;
        end
    endtask

    task automatic do_op(input int r, input int op, input int a, input logic [DW-1:0] w,
                         input string tag);
        logic [DW-1:0] exp;
        string t;
        t = (tag == "") ? op_tag(op) : tag;
        @(negedge clk);
        req_op[r*3 +: 3]     = 3'(op);
        req_addr[r*AW +: AW] = AW'(a);
        req_wdata[r*DW +: DW] = w;
        req_valid = NREQ'(1) << r;
        #1 chk("R2", 32'(grant), 32'(NREQ'(1) << r));
        model(r, op, a, w, exp);
        @(negedge clk);
        req_valid = '0;
        chk("R3", 32'(rsp_valid), 32'(NREQ'(1) << r));
        chk(t, 32'(rsp_data), 32'(exp));
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        for (int i = 0; i < NREQ; i++) begin m_rv[i] = 0; m_ra[i] = 0; end
        rst_n = 1'b0; req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(rsp_valid), 0);

        // R1: memory clears to zero
        for (int a = 0; a < DEPTH; a++) do_op(0, 0, a, '0, "R1");

        // R7: lock acquire then already held
        do_op(1, 3, 2, '0, "R7");
        do_op(2, 3, 2, '0, "R7");
        // R8: increment wraps
        do_op(0, 1, 3, 16'hFFFF, "R5");
        do_op(1, 4, 3, '0, "R8");
        do_op(1, 0, 3, '0, "R8");
        // R6 exchange, R4 code 7 as load
        do_op(2, 2, 1, 16'h5A5A, "R6");
        do_op(3, 2, 1, 16'h1234, "R6");
        do_op(3, 7, 1, 16'hFFFF, "R4");
        do_op(0, 0, 1, '0, "R4");

        // R10: linked pair succeeds, second conditional fails
        do_op(0, 5, 5, '0, "R9");
        do_op(0, 6, 5, 16'h00AA, "R10");
        do_op(0, 6, 5, 16'h00BB, "R10");
        do_op(0, 0, 5, '0, "R10");
        // R10: conditional without link, and to another address
        do_op(1, 6, 6, 16'h0077, "R10");
        do_op(1, 5, 6, '0, "R9");
        do_op(1, 6, 7, 16'h0077, "R10");
        do_op(1, 0, 7, '0, "R10");
        // R11: store by another requester breaks the link
        do_op(0, 5, 4, '0, "R9");
        do_op(1, 1, 4, 16'h0042, "R11");
        do_op(0, 6, 4, 16'h0099, "R11");
        do_op(0, 0, 4, '0, "R11");
        // R11: increment by another requester breaks the link
        do_op(2, 5, 4, '0, "R9");
        do_op(3, 4, 4, '0, "R11");
        do_op(2, 6, 4, 16'h0001, "R11");
        // R11: own plain store keeps own link; R9 relink replaces address
        do_op(3, 5, 8, '0, "R9");
        do_op(3, 1, 8, 16'h0005, "R11");
        do_op(3, 6, 8, 16'h0006, "R11");
        do_op(2, 5, 9, '0, "R9");
        do_op(2, 5, 10, '0, "R9");
        do_op(2, 6, 9, 16'h0003, "R9");

        // R2: round robin after requester 3 was last served
        do_op(3, 0, 0, '0, "R4");
        @(negedge clk);
        for (int r = 0; r < NREQ; r++) begin
            req_op[r*3 +: 3] = 3'd0;
            req_addr[r*AW +: AW] = AW'(r);
        end
        req_valid = '1;
        for (int k = 0; k < NREQ; k++) begin
            #1 chk("R2", 32'(grant), 32'(NREQ'(1) << k));
            @(negedge clk);
            chk("R3", 32'(rsp_valid), 32'(NREQ'(1) << k));
            req_valid[k] = 1'b0;
        end
        req_valid = 4'b1010;
        #1 chk("R2", 32'(grant), 32'h2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1 chk("R2", 32'(grant), 32'h8);
        @(negedge clk);
        req_valid = '0;
        chk("R3", 32'(rsp_valid), 32'h8);
        @(negedge clk);
        chk("R3", 32'(rsp_valid), 0);

        // Random mix on four addresses
        for (int n = 0; n < 400; n++) begin
            int r, op, a;
            logic [DW-1:0] w;
            r  = int'($urandom % NREQ);
            op = int'($urandom % 8);
            a  = int'($urandom % 4);
            w  = ($urandom % 4 == 0) ? 16'hFFFF : DW'($urandom);
            do_op(r, op, a, w, "");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule